// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block guards a system against software that stops making progress. A down-counter runs from a reload value picked out of sixteen power-of-two ranges. Software proves that it is alive by writing a key word to a restart register, which refills the counter. If the counter is allowed to reach zero, the block times out.

The response to a timeout depends on a mode bit. In direct mode the block drives its system reset output straight away. In two-stage mode the first timeout raises an interrupt and the counter refills. If that interrupt has not been acknowledged by the time of the next timeout, the block then drives the reset. The reset output stays high for a programmable number of cycles, 2 to 256. When the pulse ends, the block returns to its reset state, which is how the watchdog itself is cleared by the reset it causes.

Software reaches the block through a synchronous write port and a read port with one cycle of latency. Nothing in the block moves a data stream, so every port is a plain control or status pin and no handshake applies.

Top module: `twostage_wdog`

## Requirements
- R1: After reset, `irq` and `sys_rst` are 0, and reads of the control word (address 0), the count (address 1) and the status word (address 2) all return 0. A read issued with `rd_en` at one rising edge shows its value on `rd_data` after that edge.
- R2: The control word at address 0 has enable in bit 0, mode in bit 1, the range select n in bits 7:4 and the pulse select k in bits 10:8. Writing it with bit 0 set while the block is disabled loads the counter with 2^(BASE_EXP+n)-1 at that edge. BASE_EXP defaults to 16.
- R3: While the block is enabled, the count drops by exactly one per clock cycle. While it is disabled, the count holds.
- R4: Writing the key word KICK_KEY to address 1 while the block is enabled reloads the counter from the selected range. Writing any other value to address 1 leaves the counter running undisturbed.
- R5: The timeout comes 2^(BASE_EXP+n) cycles after the last load, counted from the load edge. In direct mode (mode bit 0) it raises `sys_rst` after that edge and leaves `irq` at 0.
- R6: In two-stage mode (mode bit 1), a timeout with no interrupt pending raises `irq`, keeps `sys_rst` at 0 and reloads the counter.
- R7: In two-stage mode, a timeout while `irq` is still pending raises `sys_rst`.
- R8: Any write to address 2 clears `irq` after that edge without reloading the counter. A later timeout then raises `irq` again instead of resetting. Status read bit 0 reports `irq`.
- R9: `sys_rst` stays high for exactly 2^(k+1) cycles.
- R10: Once enable is set, writing the control word with bit 0 clear does not disable the block; only a reset clears enable.
- R11: At the end of the reset pulse, the block returns to its reset state: enable, mode, range, pulse select, count and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 restart key, 2 interrupt acknowledge |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address: 0 control, 1 count, 2 status |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | First-stage timeout interrupt |
| sys_rst | output | 1 | System reset pulse |

## Verification
Call the edge that loads the counter E0. The counter shows 2^(BASE_EXP+n)-1 right after E0, reaches zero after edge 2^(BASE_EXP+n)-1, and the timeout outcome (`irq` or `sys_rst`) appears right after edge 2^(BASE_EXP+n). A reset pulse raised after edge T falls after edge T+2^(k+1). A read sampled at an edge returns the count as it stood before that edge. A register write takes effect at its own edge. The bench builds the design with BASE_EXP=4 so that these windows stay short. It counts edges from every write and read task, checks each output on the falling edge one cycle before its due edge and again just after it, and predicts every read value from the edge at which the read was sampled.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 32;
  localparam int RANGE_W = 4;
  localparam int PULSE_W = 3;
  // Pulse counter holds up to 2^(2^PULSE_W) - 1.
  localparam int PCNT_W  = 1 << PULSE_W;

  // Control word bit positions.
  localparam int CB_EN     = 0;
  localparam int CB_MODE   = 1;
  localparam int CB_RANGE  = 4;
  localparam int CB_PULSE  = 8;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PULSE_W-1:0] pulse;
    logic [RANGE_W-1:0] range;
    logic               mode;
    logic               en;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CB_EN]                        = c.en;
    w[CB_MODE]                      = c.mode;
    w[CB_RANGE +: RANGE_W]          = c.range;
    w[CB_PULSE +: PULSE_W]          = c.pulse;
    return w;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter logic [31:0] KICK_KEY = 32'h6B1D_C0A5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [CNT_W-1:0]    cnt,
  input  logic                irq,
  input  logic                hold,
  input  logic                self_clear,
  output ctrl_t               ctrl,
  output logic                load,
  output logic [RANGE_W-1:0]  load_range,
  output logic                irq_clr,
  output logic [DATA_W-1:0]   rd_data
);
  logic     wr_ok;
  logic     start;
  logic     kick;
  reg_sel_e wsel;
  reg_sel_e rsel;

  assign wsel  = reg_sel_e'(wr_addr);
  assign rsel  = reg_sel_e'(rd_addr);
  assign wr_ok = wr_en && !hold;

  assign start = wr_ok && (wsel == SEL_CTRL) && wr_data[CB_EN] && !ctrl.en;
  assign kick  = wr_ok && (wsel == SEL_COUNT) && (wr_data == KICK_KEY) && ctrl.en;
  assign irq_clr = wr_ok && (wsel == SEL_STAT);

  assign load       = start || kick;
  assign load_range = start ? wr_data[CB_RANGE +: RANGE_W] : ctrl.range;

  always_ff @(posedge clk) begin
    if (!rst_n || self_clear) begin
      ctrl <= '0;
    end else if (wr_ok && (wsel == SEL_CTRL)) begin
      ctrl.en    <= ctrl.en | wr_data[CB_EN];
      ctrl.mode  <= wr_data[CB_MODE];
      ctrl.range <= wr_data[CB_RANGE +: RANGE_W];
      ctrl.pulse <= wr_data[CB_PULSE +: PULSE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      unique case (rsel)
        SEL_CTRL:  rd_data <= ctrl_to_word(ctrl);
        SEL_COUNT: rd_data <= DATA_W'(cnt);
        SEL_STAT:  rd_data <= {{(DATA_W-1){1'b0}}, irq};
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               load,
  input  logic [RANGE_W-1:0] load_range,
  input  logic               self_clear,
  output logic [CNT_W-1:0]   cnt,
  output logic               tmo
);
  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] range_val(input logic [RANGE_W-1:0] r);
    logic [CNT_W:0] p;
    p = ONE << (BASE_EXP + int'(r));
    return CNT_W'(p - ONE);
  endfunction

  assign tmo = run && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || self_clear) begin
      cnt <= '0;
    end else if (load || tmo) begin
      cnt <= range_val(load_range);
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
  import wdog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tmo,
  input  logic               mode,
  input  logic [PULSE_W-1:0] pulse_sel,
  input  logic               irq_clr,
  output logic               irq,
  output logic               active,
  output logic               done
);
  localparam logic [PCNT_W:0] P_ONE = {{PCNT_W{1'b0}}, 1'b1};

  logic [PCNT_W-1:0] pcnt;
  logic              irq_left;
  logic [PCNT_W:0]   plen;

  assign done     = active && (pcnt == '0);
  assign irq_left = irq && !irq_clr;
  assign plen     = P_ONE << (int'(pulse_sel) + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      active <= 1'b0;
      pcnt   <= '0;
    end else if (active) begin
      if (done) begin
        active <= 1'b0;
        irq    <= 1'b0;
      end else begin
        pcnt <= pcnt - 1'b1;
      end
    end else if (tmo) begin
      if (!mode || irq_left) begin
        active <= 1'b1;
        pcnt   <= PCNT_W'(plen - P_ONE);
      end else begin
        irq <= 1'b1;
      end
    end else if (irq_clr) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog
  import wdog_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter int          BASE_EXP = 16,
  parameter logic [31:0] KICK_KEY = 32'h6B1D_C0A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq,
  output logic              sys_rst
);
  ctrl_t               ctrl;
  logic                load;
  logic [RANGE_W-1:0]  load_range;
  logic                irq_clr;
  logic [CNT_W-1:0]    cnt;
  logic                tmo;
  logic                run;
  logic                active;
  logic                done;

  assign run     = ctrl.en && !active;
  assign sys_rst = active;

  wdog_regs #(.CNT_W(CNT_W), .KICK_KEY(KICK_KEY)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .cnt(cnt), .irq(irq), .hold(active), .self_clear(done),
    .ctrl(ctrl), .load(load), .load_range(load_range),
    .irq_clr(irq_clr), .rd_data(rd_data)
  );

  wdog_counter #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .load(load),
    .load_range(load_range), .self_clear(done),
    .cnt(cnt), .tmo(tmo)
  );

  wdog_escalate u_escalate (
    .clk(clk), .rst_n(rst_n), .tmo(tmo), .mode(ctrl.mode),
    .pulse_sel(ctrl.pulse), .irq_clr(irq_clr),
    .irq(irq), .active(active), .done(done)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               mode,
  input logic [PULSE_W-1:0] pulse,
  input logic               run,
  input logic               load,
  input logic [RANGE_W-1:0] load_range,
  input logic               irq_clr,
  input logic [CNT_W-1:0]   cnt,
  input logic               tmo,
  input logic               irq,
  input logic               sys_rst,
  input logic               done
);
  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] want_load(input logic [RANGE_W-1:0] r);
    logic [CNT_W:0] p;
    p = ONE << (BASE_EXP + int'(r));
    return CNT_W'(p - ONE);
  endfunction

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == want_load($past(load_range))));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  p_direct_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !mode) |=> (sys_rst && !irq));

  p_first_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && mode && !irq) |=> (irq && !sys_rst));

  p_escalate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && mode && irq && !irq_clr) |=> sys_rst);

  p_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !tmo && !sys_rst) |=> !irq);

  p_sticky_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !done) |=> en);

  p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!sys_rst && !irq && !en && cnt == '0));

  // R9: measure each reset pulse with a counter.
  logic                prev_rst;
  logic [9:0]          run_len;
  logic [PULSE_W-1:0]  k_cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_rst <= 1'b0;
      run_len  <= '0;
      k_cap    <= '0;
    end else begin
      prev_rst <= sys_rst;
      if (sys_rst && !prev_rst) begin
        run_len <= 10'd1;
        k_cap   <= pulse;
      end else if (sys_rst) begin
        run_len <= run_len + 10'd1;
      end
      if (!sys_rst && prev_rst) begin
        p_pulse_len_r9: assert (run_len == (10'd1 << (int'(k_cap) + 1)))
          else $error("reset pulse length %0d for select %0d", run_len, k_cap);
      end
    end
  end
endmodule

bind twostage_wdog wdog_checker #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) u_wdog_checker (
  .clk(clk), .rst_n(rst_n), .en(ctrl.en), .mode(ctrl.mode), .pulse(ctrl.pulse),
  .run(run), .load(load), .load_range(load_range), .irq_clr(irq_clr),
  .cnt(cnt), .tmo(tmo), .irq(irq), .sys_rst(sys_rst), .done(done)
);

// File: tb/twostage_wdog_bench.sv
module twostage_wdog_bench;
  localparam logic [31:0] KEY = 32'h6B1D_C0A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic        sys_rst;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  twostage_wdog #(.CNT_W(32), .BASE_EXP(4), .KICK_KEY(KEY)) u_twostage_wdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .sys_rst(sys_rst)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: bench hung, actual cycles=%0d expected below 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [31:0] cw(input logic en, input logic md,
                                     input logic [3:0] rg, input logic [2:0] pk);
    return {21'b0, pk, rg, 2'b00, md, en};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    do_reset();
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 sys_rst", {31'b0, sys_rst}, 0);
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 count", v, 0);
    rd(2'd1, v); check("R3 count holds disabled", v, 0);
    rd(2'd2, v); check("R1 status", v, 0);
  endtask

  task automatic t_range_sticky();
    logic [31:0] v;
    do_reset();
    wr(2'd0, cw(1, 0, 4'd2, 3'd3));            // E0: load 63
    rd(2'd1, v); check("R2 range 2 load", v, 63);       // E1
    rd(2'd1, v); check("R3 one step per cycle", v, 62); // E2
    wr(2'd0, cw(0, 0, 4'd2, 3'd3));            // E3
    rd(2'd1, v); check("R10 still counting", v, 60);    // E4
    rd(2'd0, v); check("R10 enable stays set", v, cw(1, 0, 4'd2, 3'd3));
  endtask

  task automatic t_kick();
    logic [31:0] v;
    do_reset();
    wr(2'd0, cw(1, 0, 4'd1, 3'd0));            // E0: load 31
    wait_cyc(10);                              // after E10
    wr(2'd1, 32'h1234_5678);                   // E11: wrong key
    rd(2'd1, v); check("R4 wrong key ignored", v, 20);  // E12
    wr(2'd1, KEY);                             // E13: reload 31
    rd(2'd1, v); check("R4 key reloads", v, 31);        // E14
    wait_cyc(30);                              // after E44
    check("R5 no reset before period", {31'b0, sys_rst}, 0);
    wait_cyc(1);                               // after E45
    check("R5 reset after kicked period", {31'b0, sys_rst}, 1);
  endtask

  task automatic t_direct();
    logic [31:0] v;
    do_reset();
    wr(2'd0, cw(1, 0, 4'd0, 3'd1));            // E0: load 15, pulse 4
    wait_cyc(15);
    check("R5 no reset at cycle 15", {31'b0, sys_rst}, 0);
    wait_cyc(1);                               // after E16
    check("R5 reset at cycle 16", {31'b0, sys_rst}, 1);
    check("R5 no irq in direct mode", {31'b0, irq}, 0);
    wait_cyc(3);                               // after E19
    check("R9 pulse still high", {31'b0, sys_rst}, 1);
    wait_cyc(1);                               // after E20
    check("R9 pulse of 4 ended", {31'b0, sys_rst}, 0);
    rd(2'd0, v); check("R11 ctrl cleared", v, 0);
    rd(2'd1, v); check("R11 count cleared", v, 0);
  endtask

  task automatic t_two_stage();
    logic [31:0] v;
    do_reset();
    wr(2'd0, cw(1, 1, 4'd0, 3'd0));            // E0
    wait_cyc(15);
    check("R6 no irq yet", {31'b0, irq}, 0);
    wait_cyc(1);                               // after E16
    check("R6 irq on first timeout", {31'b0, irq}, 1);
    check("R6 no reset on first timeout", {31'b0, sys_rst}, 0);
    wait_cyc(15);                              // after E31
    check("R7 no reset before second timeout", {31'b0, sys_rst}, 0);
    wait_cyc(1);                               // after E32
    check("R7 reset on second timeout", {31'b0, sys_rst}, 1);
    wait_cyc(1);                               // after E33
    check("R9 pulse of 2 still high", {31'b0, sys_rst}, 1);
    wait_cyc(1);                               // after E34
    check("R9 pulse of 2 ended", {31'b0, sys_rst}, 0);
    check("R11 irq cleared", {31'b0, irq}, 0);
    rd(2'd2, v); check("R11 status cleared", v, 0);
  endtask

  task automatic t_ack();
    logic [31:0] v;
    do_reset();
    wr(2'd0, cw(1, 1, 4'd0, 3'd0));            // E0
    wait_cyc(16);                              // after E16
    rd(2'd2, v); check("R8 status shows irq", v, 1);    // E17
    wr(2'd2, 32'h0);                           // E18: ack
    check("R8 irq cleared", {31'b0, irq}, 0);
    rd(2'd1, v); check("R8 ack does not reload", v, 13); // E19
    wait_cyc(12);                              // after E31
    check("R8 quiet before next timeout", {31'b0, irq | sys_rst}, 0);
    wait_cyc(1);                               // after E32
    check("R8 irq again after ack", {31'b0, irq}, 1);
    check("R8 no reset after ack", {31'b0, sys_rst}, 0);
  endtask

  task automatic t_long_pulse();
    do_reset();
    wr(2'd0, cw(1, 0, 4'd0, 3'd7));            // E0
    wait_cyc(16);                              // after E16
    check("R9 long pulse starts", {31'b0, sys_rst}, 1);
    wait_cyc(255);                             // after E271
    check("R9 long pulse still high", {31'b0, sys_rst}, 1);
    wait_cyc(1);                               // after E272
    check("R9 pulse of 256 ended", {31'b0, sys_rst}, 0);
  endtask

  initial begin
    t_reset_state();
    t_range_sticky();
    t_kick();
    t_direct();
    t_two_stage();
    t_ack();
    t_long_pulse();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule